// File: doc/BRIEF.md
# Error Event Interrupt Aggregator

This block gathers single-bit error events, organised as groups of 32, and turns them into two interrupt lines: a high-priority error interrupt for faults that need immediate attention and a low-priority one for the rest. Each event has an enable and a routing bit, both written by software. Each event is also classed at build time as a level event or a pulse event. A level event is pending while its input is high. A pulse event is captured on the rising edge of its input and held until software clears it.

A small register port with a valid/ready handshake gives software four registers per group: raw status, enable clear, enable set and routing. It also has a summary register and a group-pending register. The summary register gives the global number of the most urgent pending high-priority event, with one result for level events and one for pulse events. The group-pending register shows which groups hold high-priority work. An interrupt handler reads the summary, services the event it names, then clears the event: a pulse event through its raw status bit, a level event by removing the condition at its source.

Top module: `err_evt_aggr`

## Requirements
- R1: After reset both interrupts are low, all raw status, enable and routing bits are 0, and the summary register at 0x024 reads 0xFFFFFFFF.
- R2: Group N registers start at 0x400 + N*0x20. Writing 1 to a bit of enable-set (+0x08) enables that event, and a written 0 has no effect. Both enable-clear (+0x04) and enable-set read back the current enables.
- R3: Writing 1 to a bit of enable-clear (+0x04) disables that event. A disabled event leaves both interrupts and all summaries, but its raw status (+0x00) is kept.
- R4: For a pulse event, the raw status bit sets on a rising edge of the input and stays set after the input falls. Writing 1 to that bit at +0x00 clears it. If a new rising edge arrives in the same cycle as the clear, the set wins.
- R5: For a level event, the raw status bit equals the input one cycle earlier. A write of 1 to it has no effect. With the default class map, bits 0..15 of every group are level events and bits 16..31 are pulse events.
- R6: An enabled, raw-pending event whose routing bit (+0x10) is 1 drives the high-priority interrupt, and one whose routing bit is 0 drives the low-priority interrupt. Each interrupt is registered, so it rises one cycle after the raw status bit.
- R7: Summary register 0x024: bits [15:0] hold the smallest global number among pending, enabled, high-routed level events, and bits [31:16] hold the same for pulse events. The global number is N*32 plus the bit index. A field reads 0xFFFF when it has no candidate.
- R8: Bit N of register 0x02C is 1 exactly when group N holds at least one pending, enabled, high-routed event.
- R9: The high-priority interrupt is low whenever both summary fields read 0xFFFF.
- R10: Reads of undefined offsets (for example 0x020, 0x40C, 0x480) return 0, and writes to them change no state.
- R11: req_ready is always 1. An accepted read returns its data with rsp_valid one cycle later, and the data reflects the state before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_GROUPS*32 | Error event inputs, indexed by global number |
| req_valid | input | 1 | Register request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register byte offset |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted (always 1) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq_hi | output | 1 | High-priority error interrupt |
| irq_lo | output | 1 | Low-priority error interrupt |

## Verification
The bench builds the block with its default parameters: four groups and the mixed class map, with the lower half of each group level and the upper half pulse. This lets a single run reach both encoder halves, compare events across groups in the same encoder, and probe the address just past the last group. A behavioural model is checked against both interrupts and every read response on every cycle. Directed sequences cover set-before-clear on pulses, a clear attempt on an asserted level, and disabling an event that is still pending.

// File: rtl/err_evt_pkg.sv
package err_evt_pkg;
  localparam int GRP_BASE   = 'h400;
  localparam int GRP_STRIDE = 'h20;
  localparam int SUM_ADDR   = 'h024;
  localparam int PEND_ADDR  = 'h02C;
  localparam logic [15:0] NONE_NUM = 16'hFFFF;

  typedef enum logic [4:0] {
    OFS_RAW  = 5'h00,
    OFS_ECLR = 5'h04,
    OFS_ESET = 5'h08,
    OFS_ROUT = 5'h10
  } grp_ofs_e;

  function automatic int grp_addr(input int g);
    return GRP_BASE + g * GRP_STRIDE;
  endfunction
endpackage

// File: rtl/err_evt_grp.sv
module err_evt_grp #(
  parameter int W = 32,
  parameter logic [W-1:0] LVL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         wr_raw,
  input  logic         wr_eset,
  input  logic         wr_eclr,
  input  logic         wr_rout,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] raw,
  output logic [W-1:0] en,
  output logic [W-1:0] rout,
  output logic [W-1:0] hi_pend,
  output logic [W-1:0] lo_pend
);
  logic [W-1:0] prev_q, lvl_q, pls_q;
  logic [W-1:0] rise_w, clr_w;

  assign rise_w = evt & ~prev_q & ~LVL_MASK;
  assign clr_w  = wr_raw ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      lvl_q  <= '0;
      pls_q  <= '0;
      en     <= '0;
      rout   <= '0;
    end else begin
      prev_q <= evt;
      lvl_q  <= evt & LVL_MASK;
      pls_q  <= ((pls_q & ~clr_w) | rise_w) & ~LVL_MASK;
      if (wr_eset)      en <= en | wdata;
      else if (wr_eclr) en <= en & ~wdata;
      if (wr_rout)      rout <= wdata;
    end
  end

  assign raw     = lvl_q | pls_q;
  assign hi_pend = raw & en & rout;
  assign lo_pend = raw & en & ~rout;
endmodule

// File: rtl/err_evt_enc.sv
module err_evt_enc #(
  parameter int N = 128
) (
  input  logic [N-1:0] vec,
  output logic [15:0]  num
);
  function automatic logic [15:0] lowest_set(input logic [N-1:0] v);
    logic [15:0] r;
    r = err_evt_pkg::NONE_NUM;
    for (int i = N - 1; i >= 0; i--)
      if (v[i]) r = 16'(i);
    return r;
  endfunction

  assign num = lowest_set(vec);
endmodule

// File: rtl/err_evt_regif.sv
module err_evt_regif #(
  parameter int NG = 4,
  parameter int DW = 32,
  parameter int AW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [NG*DW-1:0] raw_all,
  input  logic [NG*DW-1:0] en_all,
  input  logic [NG*DW-1:0] rout_all,
  input  logic [15:0]    lvl_num,
  input  logic [15:0]    pls_num,
  input  logic [NG-1:0]  grp_pend,
  output logic           req_ready,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_rdata,
  output logic [NG-1:0]  wr_raw,
  output logic [NG-1:0]  wr_eset,
  output logic [NG-1:0]  wr_eclr,
  output logic [NG-1:0]  wr_rout
);
  import err_evt_pkg::*;

  logic          wr_w, rd_w;
  logic [4:0]    ofs_w;
  logic [NG-1:0] sel_w;
  logic [DW-1:0] grp_rd [NG];
  logic [DW-1:0] rd_mux;

  assign req_ready = 1'b1;
  assign wr_w  = req_valid && req_write;
  assign rd_w  = req_valid && !req_write;
  assign ofs_w = req_addr[4:0];

  for (genvar g = 0; g < NG; g++) begin : g_dec
    localparam logic [AW-1:0] BASE = AW'(grp_addr(g));
    assign sel_w[g]   = (req_addr[AW-1:5] == BASE[AW-1:5]);
    assign wr_raw[g]  = wr_w && sel_w[g] && ofs_w == OFS_RAW;
    assign wr_eclr[g] = wr_w && sel_w[g] && ofs_w == OFS_ECLR;
    assign wr_eset[g] = wr_w && sel_w[g] && ofs_w == OFS_ESET;
    assign wr_rout[g] = wr_w && sel_w[g] && ofs_w == OFS_ROUT;

    always_comb begin
      grp_rd[g] = '0;
      if (sel_w[g]) begin
        case (ofs_w)
          OFS_RAW:            grp_rd[g] = raw_all[g*DW +: DW];
          OFS_ECLR, OFS_ESET: grp_rd[g] = en_all[g*DW +: DW];
          OFS_ROUT:           grp_rd[g] = rout_all[g*DW +: DW];
          default:            grp_rd[g] = '0;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (req_addr == AW'(SUM_ADDR))
      rd_mux = DW'({pls_num, lvl_num});
    else if (req_addr == AW'(PEND_ADDR))
      rd_mux = DW'(grp_pend);
    else
      for (int g = 0; g < NG; g++) rd_mux = rd_mux | grp_rd[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_w;
      if (rd_w) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/err_evt_aggr.sv
module err_evt_aggr #(
  parameter int NUM_GROUPS = 4,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 12,
  parameter logic [NUM_GROUPS*DATA_W-1:0] LEVEL_MAP =
    {NUM_GROUPS{{(DATA_W/2){1'b0}}, {(DATA_W/2){1'b1}}}}
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_GROUPS*DATA_W-1:0] evt_i,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [DATA_W-1:0]            req_wdata,
  output logic                         req_ready,
  output logic                         rsp_valid,
  output logic [DATA_W-1:0]            rsp_rdata,
  output logic                         irq_hi,
  output logic                         irq_lo
);
  localparam int NUM_EVT = NUM_GROUPS * DATA_W;

  logic [NUM_EVT-1:0]    raw_all, en_all, rout_all, hi_pend_all, lo_pend_all;
  logic [NUM_GROUPS-1:0] wr_raw, wr_eset, wr_eclr, wr_rout, grp_pend;
  logic [15:0]           lvl_num, pls_num;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    err_evt_grp #(
      .W(DATA_W), .LVL_MASK(LEVEL_MAP[g*DATA_W +: DATA_W])
    ) u_grp (
      .clk(clk), .rst_n(rst_n),
      .evt(evt_i[g*DATA_W +: DATA_W]),
      .wr_raw(wr_raw[g]), .wr_eset(wr_eset[g]),
      .wr_eclr(wr_eclr[g]), .wr_rout(wr_rout[g]),
      .wdata(req_wdata),
      .raw(raw_all[g*DATA_W +: DATA_W]),
      .en(en_all[g*DATA_W +: DATA_W]),
      .rout(rout_all[g*DATA_W +: DATA_W]),
      .hi_pend(hi_pend_all[g*DATA_W +: DATA_W]),
      .lo_pend(lo_pend_all[g*DATA_W +: DATA_W])
    );
    assign grp_pend[g] = |hi_pend_all[g*DATA_W +: DATA_W];
  end

  err_evt_enc #(.N(NUM_EVT)) u_enc_lvl (.vec(hi_pend_all & LEVEL_MAP),  .num(lvl_num));
  err_evt_enc #(.N(NUM_EVT)) u_enc_pls (.vec(hi_pend_all & ~LEVEL_MAP), .num(pls_num));

  err_evt_regif #(.NG(NUM_GROUPS), .DW(DATA_W), .AW(ADDR_W)) u_regif (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .raw_all(raw_all), .en_all(en_all), .rout_all(rout_all),
    .lvl_num(lvl_num), .pls_num(pls_num), .grp_pend(grp_pend),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .wr_raw(wr_raw), .wr_eset(wr_eset), .wr_eclr(wr_eclr), .wr_rout(wr_rout)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_hi <= 1'b0;
      irq_lo <= 1'b0;
    end else begin
      irq_hi <= |hi_pend_all;
      irq_lo <= |lo_pend_all;
    end
  end
endmodule

// File: rtl/err_evt_aggr_chk.sv
module err_evt_aggr_chk #(
  parameter int NUM_EVT = 128,
  parameter int NG      = 4,
  parameter logic [NUM_EVT-1:0] LEVEL_MAP = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               req_valid,
  input logic               req_write,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               irq_hi,
  input logic               irq_lo,
  input logic [NUM_EVT-1:0] raw_all,
  input logic [NUM_EVT-1:0] lo_pend_all,
  input logic [NG-1:0]      grp_pend,
  input logic [15:0]        lvl_num,
  input logic [15:0]        pls_num
);
  p_irq_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi == $past(|grp_pend));

  p_irq_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo == $past(|lo_pend_all));

  p_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_num == 16'hFFFF && pls_num == 16'hFFFF) |-> grp_pend == '0);

  p_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_all & LEVEL_MAP) == ($past(evt_i) & LEVEL_MAP));

  p_read_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);
endmodule

bind err_evt_aggr err_evt_aggr_chk #(
  .NUM_EVT(NUM_EVT), .NG(NUM_GROUPS), .LEVEL_MAP(LEVEL_MAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
  .req_valid(req_valid), .req_write(req_write), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .irq_hi(irq_hi), .irq_lo(irq_lo),
  .raw_all(raw_all), .lo_pend_all(lo_pend_all), .grp_pend(grp_pend),
  .lvl_num(lvl_num), .pls_num(pls_num)
);

// File: tb/err_evt_aggr_test.sv
module err_evt_aggr_test;
  localparam int NE = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] evt = '0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [11:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          req_ready, rsp_valid, irq_hi, irq_lo;
  logic [31:0]   rsp_rdata;

  int checks = 0, fails = 0;
  bit done = 0;
  string rd_tag = "R11";

  always #4 clk = ~clk;

  err_evt_aggr uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .irq_hi(irq_hi), .irq_lo(irq_lo)
  );

  // ---- behavioural reference ----
  bit m_raw[NE], m_en[NE], m_rt[NE], m_prev[NE];
  bit exp_hi, exp_lo, exp_rv;
  logic [31:0] exp_rd;

  function automatic bit is_level(int i);
    return (i % 32) < 16;
  endfunction

  function automatic bit live(int i, bit hi);
    return m_raw[i] && m_en[i] && (m_rt[i] == hi);
  endfunction

  function automatic int first_hi(bit lvl);
    for (int i = 0; i < NE; i++)
      if (live(i, 1) && is_level(i) == lvl) return i;
    return 'hFFFF;
  endfunction

  function automatic logic [31:0] mread(logic [11:0] a);
    logic [31:0] r;
    int g, o;
    r = 0;
    if (a == 12'h024) begin
      r[15:0]  = 16'(first_hi(1));
      r[31:16] = 16'(first_hi(0));
    end else if (a == 12'h02C) begin
      for (int i = 0; i < NE; i++) if (live(i, 1)) r[i/32] = 1'b1;
    end else if (a >= 12'h400 && a < 12'h480) begin
      g = (int'(a) - 'h400) / 32;
      o = (int'(a) - 'h400) % 32;
      for (int b = 0; b < 32; b++) begin
        case (o)
          0:       r[b] = m_raw[g*32+b];
          4, 8:    r[b] = m_en[g*32+b];
          16:      r[b] = m_rt[g*32+b];
          default: r[b] = 1'b0;
        endcase
      end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_raw[i]) begin m_raw[i]=0; m_en[i]=0; m_rt[i]=0; m_prev[i]=0; end
      exp_hi = 0; exp_lo = 0; exp_rv = 0;
    end else begin
      exp_hi = 0; exp_lo = 0;
      for (int i = 0; i < NE; i++) begin
        if (live(i, 1)) exp_hi = 1;
        if (live(i, 0)) exp_lo = 1;
      end
      exp_rv = req_valid && !req_write;
      if (exp_rv) exp_rd = mread(req_addr);
      for (int i = 0; i < NE; i++) begin
        automatic int g = i / 32, b = i % 32;
        automatic bit hit = req_valid && req_write &&
                            req_addr[11:5] == 7'(('h400 + g*32) >> 5);
        automatic logic [4:0] o = req_addr[4:0];
        if (is_level(i)) m_raw[i] = evt[i];
        else begin
          if (hit && o == 5'h00 && req_wdata[b]) m_raw[i] = 0;
          if (evt[i] && !m_prev[i]) m_raw[i] = 1;
        end
        if (hit && o == 5'h08 && req_wdata[b]) m_en[i] = 1;
        if (hit && o == 5'h04 && req_wdata[b]) m_en[i] = 0;
        if (hit && o == 5'h10) m_rt[i] = req_wdata[b];
        m_prev[i] = evt[i];
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R6 irq_hi", 32'(irq_hi), 32'(exp_hi));
    check("R6 irq_lo", 32'(irq_lo), 32'(exp_lo));
    check("R11 rsp_valid", 32'(rsp_valid), 32'(exp_rv));
    if (exp_rv) check(rd_tag, rsp_rdata, exp_rd);
  end

  // ---- access tasks ----
  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] expv, string tag);
    @(negedge clk);
    rd_tag = tag;
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    #1 check(tag, rsp_rdata, expv);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] lfsr;
    cyc(3);
    rst_n = 1;
    // R1 reset state
    check("R1 irq", {30'b0, irq_hi, irq_lo}, 32'h0);
    rd(12'h024, 32'hFFFF_FFFF, "R1 summary");
    rd(12'h404, 32'h0, "R1 enables");
    rd(12'h410, 32'h0, "R1 routing");

    // R2 enable set / no effect of zero
    wr(12'h408, 32'h0001_0003);
    wr(12'h408, 32'h0);
    rd(12'h404, 32'h0001_0003, "R2 enable via clear reg");
    rd(12'h408, 32'h0001_0003, "R2 enable via set reg");

    // R6 routing
    wr(12'h410, 32'h0001_0001);
    evt[1] = 1;  cyc(2);
    check("R6 low route", {30'b0, irq_hi, irq_lo}, 32'h1);
    rd(12'h024, 32'hFFFF_FFFF, "R7 low-routed not summarised");
    @(negedge clk); evt[16] = 1; cyc(2);
    check("R6 high route", 32'(irq_hi), 32'h1);
    rd(12'h024, 32'h0010_FFFF, "R7 pulse field");
    evt[16] = 0; cyc(1);
    rd(12'h400, 32'h0001_0002, "R4 pulse held");
    evt[0] = 1; cyc(1);
    rd(12'h024, 32'h0010_0000, "R7 both fields");
    rd(12'h02C, 32'h1, "R8 group 0");

    // R5 level cannot be cleared while asserted
    wr(12'h400, 32'h0000_0001);
    rd(12'h400, 32'h0001_0003, "R5 level clear ignored");

    // cross-group pulse, R4 clear, R7 ordering
    wr(12'h448, 32'h0010_0000);
    wr(12'h450, 32'h0010_0000);
    @(negedge clk); evt[84] = 1; @(negedge clk); evt[84] = 0;
    rd(12'h024, 32'h0010_0000, "R7 lowest wins");
    rd(12'h02C, 32'h5, "R8 groups 0 and 2");
    wr(12'h400, 32'h0001_0000);
    rd(12'h024, 32'h0054_0000, "R4 pulse cleared, next is 84");

    // R4 set wins over same-cycle clear
    @(negedge clk);
    evt[16] = 1; req_valid = 1; req_write = 1; req_addr = 12'h400; req_wdata = 32'h0001_0000;
    @(negedge clk); req_valid = 0; req_write = 0; evt[16] = 0;
    rd(12'h400, 32'h0001_0003, "R4 set beats clear");
    wr(12'h400, 32'h0001_0000);

    // R3 disable keeps raw
    wr(12'h444, 32'h0010_0000);
    rd(12'h444, 32'h0, "R3 enable cleared");
    rd(12'h440, 32'h0010_0000, "R3 raw kept");
    rd(12'h02C, 32'h1, "R3 group 2 gone");
    rd(12'h024, 32'hFFFF_0000, "R3 pulse field none");

    // R10 undefined offsets
    rd(12'h020, 32'h0, "R10 undefined low");
    rd(12'h40C, 32'h0, "R10 undefined in group");
    rd(12'h480, 32'h0, "R10 past last group");
    wr(12'h02C, 32'hFFFF_FFFF);
    wr(12'h48C, 32'hFFFF_FFFF);
    rd(12'h02C, 32'h1, "R10 write ignored");

    // R9 everything cleared
    evt = '0;
    wr(12'h440, 32'h0010_0000);
    cyc(2);
    rd(12'h024, 32'hFFFF_FFFF, "R9 summary none");
    check("R9 irq_hi low", 32'(irq_hi), 32'h0);
    rd(12'h440, 32'h0, "R4 group 2 cleared");

    // mixed traffic against model
    for (int g = 0; g < 4; g++) begin
      wr(12'(12'h408 + g*32), 32'hFFFF_FFFF);
      wr(12'(12'h410 + g*32), (g % 2) ? 32'hAAAA_5555 : 32'h5555_AAAA);
    end
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      evt[lfsr[6:0]] = ~evt[lfsr[6:0]];
      if (lfsr[3:0] == 4'h3) evt[lfsr[12:7]] = ~evt[lfsr[12:7]];
      case (lfsr[9:8])
        2'd0: begin rd_tag = "R7 random summary"; req_valid = 1; req_write = 0; req_addr = 12'h024; end
        2'd1: begin rd_tag = "R8 random pending"; req_valid = 1; req_write = 0; req_addr = 12'h02C; end
        2'd2: if (lfsr[11]) begin
                req_valid = 1; req_write = 1;
                req_addr = 12'(12'h400 + int'(lfsr[15:14]) * 32); req_wdata = {2{lfsr}};
              end
        default: if (lfsr[10]) begin
                req_valid = 1; req_write = 1;
                req_addr = 12'(12'h404 + int'(lfsr[15:14]) * 32); req_wdata = 32'(lfsr) << 16;
              end
      endcase
      @(negedge clk);
      req_valid = 0; req_write = 0;
    end
    cyc(3);
    finish_run();
  end
endmodule